// File: doc/BRIEF.md
# Special-Purpose Register Move Unit

This unit executes the two instructions that move data between the general-purpose register file and a small bank of 64-bit special-purpose registers. It decodes a 32-bit instruction word whenever a valid strobe is high. A move-to copies the source GPR value, which the core supplies, into one special register. A move-from returns a destination GPR write carrying that register's value.

The 10-bit register field in the instruction holds the register number with its two 5-bit halves exchanged, so the unit swaps them back before decoding. Six numbers are implemented. A block of four reserved numbers completes without effect. Every other number raises an illegal-instruction flag and leaves all state unchanged. Results are registered and appear one clock after the instruction, together with a done strobe.

Top module: `spr_move_unit`

## Requirements
- R1: An instruction is recognised only when `insn_valid` is high, bits 31:26 equal 31, and bits 10:1 equal 467 (move-to) or 339 (move-from). Bit 0 is ignored. Any other word produces no done, no illegal flag, no GPR write and no register change.
- R2: The register number is `{insn[15:11], insn[20:16]}`. Field bits 20:16 supply the low half and bits 15:11 supply the high half.
- R3: A move-to an implemented number (1, 8, 9, 26, 27 or 815) stores all 64 bits of `gpr_rdata` into that register at the clock edge that ends the instruction cycle.
- R4: One cycle after a move-from an implemented number, `done` and `gpr_we` are high, `gpr_widx` equals `insn[25:21]`, and `gpr_wdata` equals the register's current value.
- R5: For numbers 808 to 811, `gpr_rd` stays low, no register changes, and one cycle later `done` is high while `gpr_we` and `illegal` are low.
- R6: For any other unimplemented number, one cycle later `done` and `illegal` are high and `gpr_we` is low, and no register changes.
- R7: `gpr_ridx` always equals `insn[25:21]`. `gpr_rd` is high in the same cycle as a valid move-to of an implemented number, and is low otherwise.
- R8: Synchronous reset clears all six registers and the `done`, `illegal` and `gpr_we` outputs to zero.
- R9: `done` is a single-cycle pulse. It is high exactly one cycle after each recognised instruction and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| gpr_rdata | input | 64 | Source GPR value for move-to |
| gpr_ridx | output | 5 | Source GPR index |
| gpr_rd | output | 1 | Source GPR is read this cycle |
| done | output | 1 | Result strobe, one cycle after the instruction |
| illegal | output | 1 | Illegal-instruction interrupt |
| gpr_we | output | 1 | Destination GPR write enable |
| gpr_widx | output | 5 | Destination GPR index |
| gpr_wdata | output | 64 | Destination GPR write data |

## Verification
A corrupted or misdirected special register is invisible at the ports until a later move-from reads that number. One cycle after that read, the corruption appears on `gpr_wdata`. For this reason every write in the stimulus, whether random or directed, is soon followed by reads, and the bench keeps a shadow bank to predict each read. A decode fault in the swap, the reserved range or the opcode match shows up immediately: `gpr_rd` goes wrong in the instruction cycle, or `done`, `illegal` or `gpr_we` goes wrong one cycle later.

// File: rtl/spr_move_unit.sv
module spr_move_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            insn_valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] gpr_rdata,
  output logic [4:0]      gpr_ridx,
  output logic            gpr_rd,
  output logic            done,
  output logic            illegal,
  output logic            gpr_we,
  output logic [4:0]      gpr_widx,
  output logic [XLEN-1:0] gpr_wdata
);
  localparam int NUM_SPR = 6;
  localparam logic [9:0] SPR_NUM [NUM_SPR] = '{10'd1, 10'd8, 10'd9, 10'd26, 10'd27, 10'd815};
  localparam logic [9:0] RSV_LO = 10'd808;
  localparam logic [9:0] RSV_HI = 10'd811;

  logic [NUM_SPR-1:0][XLEN-1:0] spr_q;
  logic [NUM_SPR-1:0] hit;
  logic [9:0] sprn;
  logic op_ok, is_mt, is_mf, any_hit, reserved, unimpl;
  logic [XLEN-1:0] rdval;

  assign op_ok    = insn_valid && (insn[31:26] == 6'd31);
  assign is_mt    = op_ok && (insn[10:1] == 10'd467);
  assign is_mf    = op_ok && (insn[10:1] == 10'd339);
  assign sprn     = {insn[15:11], insn[20:16]};
  assign reserved = (sprn >= RSV_LO) && (sprn <= RSV_HI);

  for (genvar g = 0; g < NUM_SPR; g++) begin : g_hit
    assign hit[g] = (sprn == SPR_NUM[g]);
  end

  assign any_hit  = |hit;
  assign unimpl   = !any_hit && !reserved;
  assign gpr_ridx = insn[25:21];
  assign gpr_rd   = is_mt && any_hit;

  always_comb begin
    rdval = '0;
    for (int i = 0; i < NUM_SPR; i++)
      if (hit[i]) rdval = rdval | spr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_q     <= '0;
      done      <= 1'b0;
      illegal   <= 1'b0;
      gpr_we    <= 1'b0;
      gpr_widx  <= '0;
      gpr_wdata <= '0;
    end else begin
      done      <= is_mt || is_mf;
      illegal   <= (is_mt || is_mf) && unimpl;
      gpr_we    <= is_mf && any_hit;
      gpr_widx  <= insn[25:21];
      gpr_wdata <= rdval;
      for (int i = 0; i < NUM_SPR; i++)
        if (is_mt && hit[i]) spr_q[i] <= gpr_rdata;
    end
  end

  p_illegal_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !gpr_we));
  p_spr_frozen_on_illegal_r6: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(spr_q));
  p_write_has_done_r4: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> done);
  p_spr_only_by_move_to_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(is_mt) |-> $stable(spr_q));
  p_reserved_no_read_r5: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && reserved) |-> !gpr_rd);
  p_done_after_valid_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(insn_valid));
endmodule

// File: tb/tb_spr_move_unit.sv
module tb_spr_move_unit;
  logic clk = 0, rst = 1, insn_valid = 0;
  logic [31:0] insn = '0;
  logic [63:0] gpr_rdata = '0;
  logic [4:0] gpr_ridx, gpr_widx;
  logic gpr_rd, done, illegal, gpr_we;
  logic [63:0] gpr_wdata;

  spr_move_unit dut (.clk, .rst, .insn_valid, .insn, .gpr_rdata, .gpr_ridx, .gpr_rd,
                     .done, .illegal, .gpr_we, .gpr_widx, .gpr_wdata);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [63:0] shadow [6];
  int impl_nums [6] = '{1, 8, 9, 26, 27, 815};

  function automatic int num_kind(int n);
    for (int i = 0; i < 6; i++) if (impl_nums[i] == n) return i;
    if (n >= 808 && n <= 811) return -2;
    return -1;
  endfunction

  function automatic logic [31:0] enc(int kind, int n, logic [4:0] g, logic b0);
    logic [9:0] num, fld, xo;
    logic [5:0] po;
    num = n[9:0];
    fld = {num[4:0], num[9:5]};
    po = 6'd31;
    xo = (kind == 0) ? 10'd467 : (kind == 1) ? 10'd339 : 10'd100;
    if (kind == 3) begin po = 6'd30; xo = 10'd467; end
    return {po, g, fld, xo, b0};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 move-to, 1 move-from, 2 bad extended opcode, 3 bad primary opcode
  task automatic issue(int kind, int n, logic [4:0] g, logic [63:0] d, logic b0);
    int k;
    bit rec, exp_rd, exp_we, exp_ill;
    k = num_kind(n);
    rec = (kind == 0 || kind == 1);
    exp_rd = (kind == 0) && (k >= 0);
    exp_we = (kind == 1) && (k >= 0);
    exp_ill = rec && (k == -1);
    @(negedge clk);
    insn = enc(kind, n, g, b0); gpr_rdata = d; insn_valid = 1;
    #1;
    chk(gpr_rd == exp_rd, "R7 gpr_rd", 64'(gpr_rd), 64'(exp_rd));
    chk(gpr_ridx == g, "R7 gpr_ridx", 64'(gpr_ridx), 64'(g));
    @(negedge clk);
    chk(done == rec, rec ? "R9 done" : "R1 done on unrecognised", 64'(done), 64'(rec));
    chk(illegal == exp_ill, (k == -2) ? "R5 illegal" : "R6 illegal", 64'(illegal), 64'(exp_ill));
    chk(gpr_we == exp_we, (k == -2) ? "R5 gpr_we" : "R4 gpr_we", 64'(gpr_we), 64'(exp_we));
    if (exp_we) begin
      chk(gpr_widx == g, "R4 gpr_widx", 64'(gpr_widx), 64'(g));
      chk(gpr_wdata == shadow[k], "R2/R4 gpr_wdata", gpr_wdata, shadow[k]);
    end
    if (exp_rd) shadow[k] = d;
    insn_valid = 0;
    insn = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) shadow[i] = '0;
    insn_valid = 1;
    insn = enc(0, 8, 5'd3, 1'b0);
    gpr_rdata = 64'hDEAD;
    repeat (3) @(negedge clk);
    chk(done == 0 && illegal == 0 && gpr_we == 0, "R8 outputs in reset", {61'd0, done, illegal, gpr_we}, 64'd0);
    insn_valid = 0;
    rst = 0;
    @(negedge clk);
    chk(done == 0, "R9 idle done", 64'(done), 64'd0);
    for (int i = 0; i < 6; i++) issue(1, impl_nums[i], 5'(i + 1), 64'd0, 1'b0); // R8 read zeros
    for (int i = 0; i < 6; i++)
      issue(0, impl_nums[i], 5'(i + 7), {32'hA5A50000 + 32'(i), 32'hFFFF0000 | 32'(impl_nums[i])}, 1'b1); // R3
    for (int i = 0; i < 6; i++) issue(1, impl_nums[i], 5'(31 - i), 64'd0, 1'b1);
    for (int n = 808; n <= 811; n++) begin issue(0, n, 5'd4, 64'h1111, 1'b0); issue(1, n, 5'd4, 64'd0, 1'b0); end // R5
    issue(0, 0, 5'd2, 64'h22, 1'b0);      // R6
    issue(1, 1023, 5'd2, 64'd0, 1'b0);    // R6
    issue(0, 32, 5'd2, 64'h33, 1'b0);     // R2: swapped form of 1 is not 1
    issue(2, 8, 5'd2, 64'h44, 1'b0);      // R1
    issue(3, 8, 5'd2, 64'h55, 1'b0);      // R1
    for (int i = 0; i < 6; i++) issue(1, impl_nums[i], 5'd9, 64'd0, 1'b0);
    @(negedge clk);
    chk(done == 0, "R9 done single pulse", 64'(done), 64'd0);
    for (int it = 0; it < 600; it++) begin
      int r, kind, n;
      r = int'($urandom_range(0, 9));
      n = (r < 6) ? impl_nums[r] : (r < 8) ? int'($urandom_range(808, 811)) : int'($urandom_range(0, 1023));
      kind = int'($urandom_range(0, 9));
      kind = (kind < 4) ? 0 : (kind < 8) ? 1 : kind - 6;
      issue(kind, n, 5'($urandom), {$urandom, $urandom}, 1'($urandom));
    end
    for (int i = 0; i < 6; i++) issue(1, impl_nums[i], 5'd1, 64'd0, 1'b0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule